// File: doc/BRIEF.md
# Pulse Width Measurement Unit

This unit times the high and the low phases of a digital input signal by counting ticks of a selectable timebase. A phase counter restarts at every level change of the input. When a level ends, its count is captured together with an overflow flag. The count can run on every base-clock cycle, or only on the ticks of one of two slower rates that a divider derives from the base clock.

Captured widths are reported in one of three ways. In single mode, each finished phase is written to a result register that carries a phase tag. In sampled mode, the most recent high and low widths are emitted as a pair on every rising edge of an external sample clock. In period mode, a pair is emitted every time a low phase closes a full high-then-low period.

The input signal and the sample clock are assumed to be synchronous to the base clock. Dropping the enable re-arms the unit. After re-arming, the phase that is in progress is thrown away, so a truncated width is never reported.

Top module: `pulse_width_meter`

## Requirements
- R1: While reset is asserted, and right after it, `rd_val`, `rd_tag`, `rd_ovf`, `rd_upd`, `smp_valid`, `smp_high`, `smp_low`, `smp_hovf` and `smp_lovf` are all zero.
- R2: The value of `tb_sel` sets the timebase. 0 or 3 counts a tick on every base-clock cycle, 1 counts a tick once every `DIV_MID` cycles, and 2 counts a tick once every `DIV_SLOW` cycles. The divider restarts when `en` is low. A phase's width is the number of ticks that fall in the cycles during which the input holds that level.
- R3: In single mode (`mode` 0 or 3), a falling edge of `sig_in` writes the finished high width with `rd_tag`=1, and a rising edge writes the finished low width with `rd_tag`=0. The write shows on the outputs one cycle after the cycle in which the edge is first seen. `rd_upd` is high for exactly that cycle, and `rd_val` does not change at any other time.
- R4: In sampled mode (`mode` 1), each 0-to-1 transition of `smp_clk` makes `smp_valid` pulse one cycle later. The pulse carries the high and low widths captured before that cycle, but only once both a high width and a low width have been captured since enable. A `smp_clk` that is held high gives no further samples.
- R5: In period mode (`mode` 2), a rising edge of `sig_in` that ends a low phase emits `smp_high` (the preceding high width) and `smp_low` (that low width) one cycle later. This happens only if a high width was captured earlier since enable.
- R6: The first level change after `en` rises only arms the unit, and the partial phase before it is never reported. Outputs hold their values while `en` is low, and no report is made.
- R7: A phase counter stops at its all-ones value instead of wrapping, and the width reported for that phase carries an overflow flag of 1 (`rd_ovf`, `smp_hovf` or `smp_lovf`). The flag is cleared for the next phase.
- R8: With the base-clock timebase, a phase that lasts N cycles (for any N of 1 or more, including the 4-cycle minimum pulse) is reported as exactly N. The default counter width is 32 bits.
- R9: In single mode `smp_valid` never pulses. In the sampled and period modes, `rd_upd` never pulses and `rd_val`, `rd_tag` and `rd_ovf` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Measurement enable; low re-arms the unit |
| sig_in | input | 1 | Signal whose phases are timed (synchronous) |
| tb_sel | input | 2 | Timebase select: 0/3 full rate, 1 mid rate, 2 slow rate |
| mode | input | 2 | Reporting mode: 0/3 single, 1 sampled, 2 period |
| smp_clk | input | 1 | Explicit sample clock (synchronous, rising edge used) |
| rd_val | output | W | Last reported phase width (single mode) |
| rd_tag | output | 1 | 1 = high-phase width, 0 = low-phase width |
| rd_ovf | output | 1 | Reported width saturated |
| rd_upd | output | 1 | One-cycle strobe for a register update |
| smp_valid | output | 1 | One-cycle strobe for a buffered sample |
| smp_high | output | W | High width in the sample |
| smp_low | output | W | Low width in the sample |
| smp_hovf | output | 1 | High width in the sample saturated |
| smp_lovf | output | 1 | Low width in the sample saturated |

## Verification
The case that is hardest to reach from the ports is saturation. At the default width a phase would have to last more than four billion ticks before the counter stops. The bench therefore builds the unit with an 8-bit width and holds one level for 300 cycles. It then checks that the reported value is all-ones with the flag set, and that the next phase comes out clean. The slow timebase also needs phases thousands of cycles long before a single tick is counted, and the bench drives such phases on purpose. A reference model that runs on every clock also covers the case where a sample-clock edge and a phase capture land in the same cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    RPT_SINGLE  = 2'd0,
    RPT_SAMPLED = 2'd1,
    RPT_PERIOD  = 2'd2,
    RPT_SINGLE2 = 2'd3
  } rpt_mode_e;

  typedef enum logic [1:0] {
    TB_FULL  = 2'd0,
    TB_MID   = 2'd1,
    TB_SLOW  = 2'd2,
    TB_FULL2 = 2'd3
  } tb_sel_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int DIV_MID  = 40,
  parameter int DIV_SLOW = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  import pwm_pkg::*;
  localparam int DW = $clog2(DIV_SLOW + 1);

  logic [DW-1:0] div_q, div_d, lim;

  always_comb begin
    unique case (tb_sel_e'(sel))
      TB_MID:  lim = DW'(DIV_MID);
      TB_SLOW: lim = DW'(DIV_SLOW);
      default: lim = DW'(1);
    endcase
    tick = en && (div_q == lim - DW'(1));
    if (!en || tick) div_d = '0;
    else             div_d = div_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sig_in,
  input  logic         tick,
  output logic         cap_stb,
  output logic         cap_high,
  output logic [W-1:0] cap_val,
  output logic         cap_ovf
);
  logic         sig_q, armed_q, ovf_q;
  logic         armed_d, ovf_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         lvl_chg;

  always_comb begin
    lvl_chg  = sig_in ^ sig_q;
    cap_stb  = en && armed_q && lvl_chg;
    cap_high = sig_q;
    cap_val  = cnt_q;
    cap_ovf  = ovf_q;
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    if (!en) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      ovf_d   = 1'b0;
    end else if (lvl_chg) begin
      armed_d = 1'b1;
      cnt_d   = tick ? W'(1) : '0;
      ovf_d   = 1'b0;
    end else if (armed_q && tick) begin
      if (&cnt_q) ovf_d = 1'b1;
      else        cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      sig_q   <= sig_in;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/pwm_report.sv
module pwm_report #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic         smp_clk,
  input  logic         cap_stb,
  input  logic         cap_high,
  input  logic [W-1:0] cap_val,
  input  logic         cap_ovf,
  output logic [W-1:0] rd_val,
  output logic         rd_tag,
  output logic         rd_ovf,
  output logic         rd_upd,
  output logic         smp_valid,
  output logic [W-1:0] smp_high,
  output logic [W-1:0] smp_low,
  output logic         smp_hovf,
  output logic         smp_lovf
);
  import pwm_pkg::*;

  logic         smp_q;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hi_ovf_q, hi_ovf_d, lo_ovf_q, lo_ovf_d;
  logic         have_hi_q, have_hi_d, have_lo_q, have_lo_d;
  logic [W-1:0] rd_val_d, smp_high_d, smp_low_d;
  logic         rd_tag_d, rd_ovf_d, rd_upd_d;
  logic         smp_valid_d, smp_hovf_d, smp_lovf_d;
  logic         is_single, is_sampled, is_period, smp_rise;

  always_comb begin
    is_single  = (rpt_mode_e'(mode) == RPT_SINGLE) || (rpt_mode_e'(mode) == RPT_SINGLE2);
    is_sampled = (rpt_mode_e'(mode) == RPT_SAMPLED);
    is_period  = (rpt_mode_e'(mode) == RPT_PERIOD);
    smp_rise   = smp_clk && !smp_q;

    hi_d        = hi_q;
    lo_d        = lo_q;
    hi_ovf_d    = hi_ovf_q;
    lo_ovf_d    = lo_ovf_q;
    have_hi_d   = have_hi_q;
    have_lo_d   = have_lo_q;
    rd_val_d    = rd_val;
    rd_tag_d    = rd_tag;
    rd_ovf_d    = rd_ovf;
    rd_upd_d    = 1'b0;
    smp_valid_d = 1'b0;
    smp_high_d  = smp_high;
    smp_low_d   = smp_low;
    smp_hovf_d  = smp_hovf;
    smp_lovf_d  = smp_lovf;

    if (!en) begin
      have_hi_d = 1'b0;
      have_lo_d = 1'b0;
    end else begin
      if (is_sampled && smp_rise && have_hi_q && have_lo_q) begin
        smp_valid_d = 1'b1;
        smp_high_d  = hi_q;
        smp_hovf_d  = hi_ovf_q;
        smp_low_d   = lo_q;
        smp_lovf_d  = lo_ovf_q;
      end
      if (cap_stb) begin
        if (is_single) begin
          rd_upd_d = 1'b1;
          rd_val_d = cap_val;
          rd_tag_d = cap_high;
          rd_ovf_d = cap_ovf;
        end
        if (cap_high) begin
          hi_d      = cap_val;
          hi_ovf_d  = cap_ovf;
          have_hi_d = 1'b1;
        end else begin
          lo_d      = cap_val;
          lo_ovf_d  = cap_ovf;
          have_lo_d = 1'b1;
          if (is_period && have_hi_q) begin
            smp_valid_d = 1'b1;
            smp_high_d  = hi_q;
            smp_hovf_d  = hi_ovf_q;
            smp_low_d   = cap_val;
            smp_lovf_d  = cap_ovf;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q     <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      hi_ovf_q  <= 1'b0;
      lo_ovf_q  <= 1'b0;
      have_hi_q <= 1'b0;
      have_lo_q <= 1'b0;
      rd_val    <= '0;
      rd_tag    <= 1'b0;
      rd_ovf    <= 1'b0;
      rd_upd    <= 1'b0;
      smp_valid <= 1'b0;
      smp_high  <= '0;
      smp_low   <= '0;
      smp_hovf  <= 1'b0;
      smp_lovf  <= 1'b0;
    end else begin
      smp_q     <= smp_clk;
      hi_q      <= hi_d;
      lo_q      <= lo_d;
      hi_ovf_q  <= hi_ovf_d;
      lo_ovf_q  <= lo_ovf_d;
      have_hi_q <= have_hi_d;
      have_lo_q <= have_lo_d;
      rd_val    <= rd_val_d;
      rd_tag    <= rd_tag_d;
      rd_ovf    <= rd_ovf_d;
      rd_upd    <= rd_upd_d;
      smp_valid <= smp_valid_d;
      smp_high  <= smp_high_d;
      smp_low   <= smp_low_d;
      smp_hovf  <= smp_hovf_d;
      smp_lovf  <= smp_lovf_d;
    end
  end
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
  parameter int W        = 32,
  parameter int DIV_MID  = 40,
  parameter int DIV_SLOW = 2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sig_in,
  input  logic [1:0]   tb_sel,
  input  logic [1:0]   mode,
  input  logic         smp_clk,
  output logic [W-1:0] rd_val,
  output logic         rd_tag,
  output logic         rd_ovf,
  output logic         rd_upd,
  output logic         smp_valid,
  output logic [W-1:0] smp_high,
  output logic [W-1:0] smp_low,
  output logic         smp_hovf,
  output logic         smp_lovf
);
  logic         tick, cap_stb, cap_high, cap_ovf;
  logic [W-1:0] cap_val;

  pwm_tick_gen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(tb_sel), .tick(tick)
  );

  pwm_phase_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .tick(tick),
    .cap_stb(cap_stb), .cap_high(cap_high), .cap_val(cap_val), .cap_ovf(cap_ovf)
  );

  pwm_report #(.W(W)) u_rpt (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .smp_clk(smp_clk),
    .cap_stb(cap_stb), .cap_high(cap_high), .cap_val(cap_val), .cap_ovf(cap_ovf),
    .rd_val(rd_val), .rd_tag(rd_tag), .rd_ovf(rd_ovf), .rd_upd(rd_upd),
    .smp_valid(smp_valid), .smp_high(smp_high), .smp_low(smp_low),
    .smp_hovf(smp_hovf), .smp_lovf(smp_lovf)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         sig_in,
  input logic [1:0]   mode,
  input logic         smp_clk,
  input logic [W-1:0] rd_val,
  input logic         rd_tag,
  input logic         rd_ovf,
  input logic         rd_upd,
  input logic         smp_valid,
  input logic [W-1:0] smp_high,
  input logic         smp_hovf
);
  assert_tag_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upd && rd_tag) |-> !$past(sig_in));
  assert_tag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upd && !rd_tag) |-> $past(sig_in));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_upd |-> $stable(rd_val));
  assert_smp_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(mode) == 2'd1) |-> ($past(smp_clk) && !$past(smp_clk, 2)));
  assert_period_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(mode) == 2'd2) |-> $past(sig_in));
  assert_need_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upd || smp_valid) |-> $past(en));
  assert_sat_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_upd && rd_ovf) |-> (&rd_val));
  assert_sat_smp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_hovf) |-> (&smp_high));
  assert_mode_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_upd |-> ($past(mode) == 2'd0 || $past(mode) == 2'd3));
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_upd, smp_valid}));
endmodule

bind pulse_width_meter pwm_checker #(.W(W)) u_pwm_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .mode(mode),
  .smp_clk(smp_clk), .rd_val(rd_val), .rd_tag(rd_tag), .rd_ovf(rd_ovf),
  .rd_upd(rd_upd), .smp_valid(smp_valid), .smp_high(smp_high), .smp_hovf(smp_hovf)
);

// File: tb/tb_pulse_width_meter.sv
`timescale 1ns/1ps
module tb_pulse_width_meter;
  localparam int W  = 8;
  localparam int DM = 40;
  localparam int DS = 2000;
  localparam longint MAXV = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sig_in = 1'b0, smp_clk = 1'b0;
  logic [1:0] tb_sel = 2'd0, mode = 2'd0;
  logic [W-1:0] rd_val, smp_high, smp_low;
  logic rd_tag, rd_ovf, rd_upd, smp_valid, smp_hovf, smp_lovf;

  always #2.5 clk = ~clk;

  pulse_width_meter #(.W(W), .DIV_MID(DM), .DIV_SLOW(DS)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .tb_sel(tb_sel),
    .mode(mode), .smp_clk(smp_clk), .rd_val(rd_val), .rd_tag(rd_tag),
    .rd_ovf(rd_ovf), .rd_upd(rd_upd), .smp_valid(smp_valid),
    .smp_high(smp_high), .smp_low(smp_low), .smp_hovf(smp_hovf), .smp_lovf(smp_lovf)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference model
  bit m_prev, m_prev_smp, m_armed, m_ovf, m_hov, m_lov, m_hhave, m_lhave;
  longint m_cnt, m_hi, m_lo;
  int m_div;
  longint e_rd_val, e_smp_hi, e_smp_lo;
  bit e_rd_tag, e_rd_ovf, e_rd_upd, e_sv, e_shov, e_slov;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_prev_smp = 0; m_armed = 0; m_ovf = 0; m_cnt = 0; m_div = 0;
      m_hi = 0; m_lo = 0; m_hov = 0; m_lov = 0; m_hhave = 0; m_lhave = 0;
      e_rd_val = 0; e_rd_tag = 0; e_rd_ovf = 0; e_rd_upd = 0;
      e_sv = 0; e_smp_hi = 0; e_smp_lo = 0; e_shov = 0; e_slov = 0;
    end else begin
      e_rd_upd = 0; e_sv = 0;
      if (!en) begin
        m_armed = 0; m_cnt = 0; m_ovf = 0; m_div = 0; m_hhave = 0; m_lhave = 0;
      end else begin
        int lim;
        bit tk;
        lim = (tb_sel == 1) ? DM : (tb_sel == 2) ? DS : 1;
        tk = (m_div == lim - 1);
        m_div = tk ? 0 : m_div + 1;
        if (mode == 1 && smp_clk && !m_prev_smp && m_hhave && m_lhave) begin
          e_sv = 1; e_smp_hi = m_hi; e_shov = m_hov; e_smp_lo = m_lo; e_slov = m_lov;
        end
        if (sig_in != m_prev) begin
          if (m_armed) begin
            if (mode == 0 || mode == 3) begin
              e_rd_upd = 1; e_rd_val = m_cnt; e_rd_tag = m_prev; e_rd_ovf = m_ovf;
            end
            if (m_prev) begin
              m_hi = m_cnt; m_hov = m_ovf; m_hhave = 1;
            end else begin
              if (mode == 2 && m_hhave) begin
                e_sv = 1; e_smp_hi = m_hi; e_shov = m_hov; e_smp_lo = m_cnt; e_slov = m_ovf;
              end
              m_lo = m_cnt; m_lov = m_ovf; m_lhave = 1;
            end
          end
          m_armed = 1; m_cnt = tk ? 1 : 0; m_ovf = 0;
        end else if (m_armed && tk) begin
          if (m_cnt == MAXV) m_ovf = 1; else m_cnt++;
        end
      end
      m_prev = sig_in; m_prev_smp = smp_clk;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if ({rd_upd, rd_tag, rd_ovf, 64'(rd_val)} != {e_rd_upd, e_rd_tag, e_rd_ovf, e_rd_val}) begin
        n_bad++;
        $display("FAIL %s rd act upd=%0d tag=%0d ovf=%0d val=%0d exp upd=%0d tag=%0d ovf=%0d val=%0d",
                 (mode == 0 || mode == 3) ? "R3" : "R9", rd_upd, rd_tag, rd_ovf, rd_val,
                 e_rd_upd, e_rd_tag, e_rd_ovf, e_rd_val);
      end
      n_cmp++;
      if ({smp_valid, smp_hovf, smp_lovf, 64'(smp_high), 64'(smp_low)} !=
          {e_sv, e_shov, e_slov, e_smp_hi, e_smp_lo}) begin
        n_bad++;
        $display("FAIL %s smp act v=%0d hi=%0d lo=%0d ho=%0d lo_o=%0d exp v=%0d hi=%0d lo=%0d ho=%0d lo_o=%0d",
                 (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R9",
                 smp_valid, smp_high, smp_low, smp_hovf, smp_lovf,
                 e_sv, e_smp_hi, e_smp_lo, e_shov, e_slov);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic lvl(input bit v, input int n);
    sig_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm(input logic [1:0] m, input logic [1:0] s, input bit v);
    en = 0; mode = m; tb_sel = s; sig_in = v;
    @(negedge clk);
    en = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rd_val == 0 && !rd_upd && !rd_tag && !rd_ovf, "R1", rd_val, 0);
    chk(!smp_valid && smp_high == 0 && smp_low == 0 && !smp_hovf && !smp_lovf, "R1", smp_high, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_val == 0 && !rd_upd && !smp_valid, "R1", rd_val, 0);

    // single mode, full rate
    rearm(2'd0, 2'd0, 1'b1);
    lvl(1, 3);
    lvl(0, 1);
    chk(rd_upd == 0, "R6", rd_upd, 0);          // partial high discarded
    lvl(0, 4);
    lvl(1, 1);
    chk(rd_upd && rd_val == 5 && rd_tag == 0, "R3", rd_val, 5);
    lvl(1, 3);
    lvl(0, 1);
    chk(rd_upd && rd_val == 4 && rd_tag == 1, "R8", rd_val, 4);
    lvl(0, 2);
    lvl(1, 1);
    chk(rd_val == 3 && rd_tag == 0, "R3", rd_val, 3);
    lvl(0, 1);
    chk(rd_val == 1 && rd_tag == 1, "R8", rd_val, 1);
    lvl(0, 3);

    // sampled mode
    rearm(2'd1, 2'd0, 1'b0);
    smp_clk = 1; @(negedge clk);
    chk(smp_valid == 0, "R4", smp_valid, 0);
    smp_clk = 0;
    lvl(0, 2);
    lvl(1, 5);
    lvl(0, 6);
    lvl(1, 2);
    smp_clk = 1; @(negedge clk);
    chk(smp_valid && smp_high == 5 && smp_low == 6, "R4", smp_high, 5);
    @(negedge clk);
    chk(smp_valid == 0, "R4", smp_valid, 0);     // held high: one sample only
    smp_clk = 0;
    chk(rd_val == 1 && rd_tag == 1, "R9", rd_val, 1);
    lvl(1, 3);
    lvl(0, 2);

    // period mode
    rearm(2'd2, 2'd0, 1'b0);
    lvl(0, 2);
    lvl(1, 6);
    lvl(0, 9);
    lvl(1, 1);
    chk(smp_valid && smp_high == 6 && smp_low == 9, "R5", smp_low, 9);
    lvl(1, 2);
    lvl(0, 2);

    // mid and slow timebases
    rearm(2'd0, 2'd1, 1'b0);
    lvl(0, 3);
    lvl(1, 100);
    lvl(0, 1);
    chk(rd_upd && rd_tag && (rd_val == 2 || rd_val == 3), "R2", rd_val, 2);
    rearm(2'd0, 2'd2, 1'b1);
    lvl(1, 50);
    lvl(0, 5000);
    lvl(1, 1);
    chk(rd_upd && !rd_tag && (rd_val == 2 || rd_val == 3), "R2", rd_val, 2);
    lvl(1, 2);

    // saturation
    rearm(2'd0, 2'd0, 1'b0);
    lvl(0, 2);
    lvl(1, 300);
    lvl(0, 1);
    chk(rd_ovf && rd_val == MAXV, "R7", rd_val, MAXV);
    lvl(0, 3);
    lvl(1, 1);
    chk(!rd_ovf && rd_val == 4, "R7", rd_val, 4);
    // saturated high inside a period sample
    rearm(2'd2, 2'd0, 1'b0);
    lvl(0, 2);
    lvl(1, 280);
    lvl(0, 7);
    lvl(1, 1);
    chk(smp_valid && smp_hovf && !smp_lovf && smp_low == 7, "R7", smp_low, 7);
    lvl(1, 3);

    // disabled: no reports
    en = 0;
    lvl(0, 3);
    lvl(1, 3);
    lvl(0, 1);
    chk(!rd_upd && !smp_valid, "R6", rd_upd, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule